// File: doc/BRIEF.md
# Disk Controller Synchronization Port

This block sits between an 8-bit processor's I/O bus and a floppy disk controller chip. It gives the processor a single I/O port that does two jobs. A read from the port stalls the processor with a wait request until the disk controller signals that a byte is ready to move (data request) or that the current command has ended (interrupt request). The read then returns the interrupt state on the top data bit. Software can therefore run a tight transfer loop with no polling: each read of this port blocks until the next byte can move, and the returned bit shows whether the command has finished.

A write to the same port latches the drive number, head side and recording density. The drive number is decoded into one active-low select line per drive. Both controller request inputs pass through a synchronizer before they reach the control logic. The wait release therefore changes only on processor clock edges.

The control logic is a three-state machine. `S_IDLE` waits for a read of the port. It moves to `S_STALL` when the read begins while neither request is present (transition *stall*). It moves directly to `S_DONE` when a request is already present (transition *pass*). `S_STALL` holds the wait line until a synchronized request appears (transition *release*, to `S_DONE`). `S_DONE` keeps wait low while the strobe is held and returns to `S_IDLE` when the strobe drops (transition *finish*). Any state goes back to `S_IDLE` on reset.

Top module: `fdc_sync_port`

## Requirements
- R1: The port answers only at I/O address 0x14 (parameter `PORT_ADDR`). A read at any other address raises no wait and returns 0x00. A write at any other address leaves every latched output unchanged.
- R2: When a read of the port begins while neither synchronized request is active, `cpu_wait` goes high in the same cycle as the strobe. It stays high as long as neither request has reached the synchronized side.
- R3: After `fdc_drq` or `fdc_intrq` rises during a stall, `cpu_wait` falls at the third rising clock edge. Two edges are spent in the synchronizer and one in the state register.
- R4: If a synchronized request is already active when the read begins, `cpu_wait` is never raised for that read.
- R5: During a read of the port, `io_rdata` bit 7 is 0 when the synchronized interrupt request is active and 1 when it is inactive. Bits 6:0 read as 0. When the port is not being read, `io_rdata` is 0x00.
- R6: Write bits 1:0 select drive 0..3. Exactly one bit of `drv_sel_n` is low: bit n for drive n.
- R7: Write bit 2 sets `head_sel`: 0 selects head 0 and 1 selects head 1.
- R8: Write bit 3 sets `dens_dbl`: 0 selects single density and 1 selects double density. Write bits 7:4 have no effect on any output.
- R9: Reset sets drive 0 (`drv_sel_n` = 4'b1110), head 0, single density, and `cpu_wait` low.
- R10: Once a read has been released, `cpu_wait` stays low until the strobe drops, even if the requests go away. The next read of the port is judged afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_rd | input | 1 | I/O read strobe, held for the whole access |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data from the processor |
| io_rdata | output | 8 | Read data to the processor |
| cpu_wait | output | 1 | Wait request to the processor, high to stall |
| fdc_drq | input | 1 | Controller data request, active high, asynchronous |
| fdc_intrq | input | 1 | Controller command-complete request, active high, asynchronous |
| drv_sel_n | output | 4 | Active-low drive selects, one per drive |
| head_sel | output | 1 | Head side select |
| dens_dbl | output | 1 | Density select, high for double density |

## Verification
The hardest case to reach is a request that arrives in the middle of a stall. The bench drives the request inputs on falling edges, away from the sampling edges, and counts edges. It shows `cpu_wait` still high after two rising edges and low after the third. A second case checks that a request already settled through the synchronizer bypasses the stall entirely. A third drops the requests while the strobe is still held, to show that the released state does not fall back into a stall. Writes carrying ones in the upper nibble, and writes to a neighbouring address, confirm that the latched outputs ignore them.

// File: rtl/fdc_sync_pkg.sv
package fdc_sync_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_STALL = 2'd1,
        S_DONE  = 2'd2
    } sync_state_e;

    typedef struct packed {
        logic       dens;
        logic       head;
        logic [1:0] drive;
    } drv_cfg_t;

    localparam drv_cfg_t CFG_RESET = '{dens: 1'b0, head: 1'b0, drive: 2'd0};

endpackage

// File: rtl/fdc_sync_cdc.sv
module fdc_sync_cdc #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/fdc_sync_fsm.sv
module fdc_sync_fsm
    import fdc_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit,
    input  logic ready_s,
    output logic wait_req
);
    sync_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (rd_hit) state_d = ready_s ? S_DONE : S_STALL;
            end
            S_STALL: begin
                if (!rd_hit)      state_d = S_IDLE;
                else if (ready_s) state_d = S_DONE;
            end
            S_DONE: begin
                if (!rd_hit) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        wait_req = 1'b0;
        unique case (state_q)
            S_IDLE:  wait_req = rd_hit && !ready_s;
            S_STALL: wait_req = rd_hit;
            S_DONE:  wait_req = 1'b0;
            default: wait_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/fdc_sync_latch.sv
module fdc_sync_latch
    import fdc_sync_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_DRV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_DRV-1:0] drv_sel_n,
    output logic               head_sel,
    output logic               dens_dbl
);
    drv_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= CFG_RESET;
        else if (wr_hit) cfg_q <= drv_cfg_t'(wdata[3:0]);
    end

    generate
        for (genvar d = 0; d < NUM_DRV; d++) begin : g_dec
            assign drv_sel_n[d] = (cfg_q.drive != 2'(d));
        end
    endgenerate

    assign head_sel = cfg_q.head;
    assign dens_dbl = cfg_q.dens;
endmodule

// File: rtl/fdc_sync_port.sv
module fdc_sync_port
    import fdc_sync_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  PORT_ADDR   = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              cpu_wait,
    input  logic              fdc_drq,
    input  logic              fdc_intrq,
    output logic [3:0]        drv_sel_n,
    output logic              head_sel,
    output logic              dens_dbl
);
    localparam int NUM_DRV = 4;

    logic       hit, rd_hit, wr_hit, ready_s;
    logic [1:0] req_s;

    assign hit    = (io_addr == ADDR_W'(PORT_ADDR));
    assign rd_hit = io_rd && hit;
    assign wr_hit = io_wr && hit;

    fdc_sync_cdc #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_cdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({fdc_intrq, fdc_drq}),
        .sync_out (req_s)
    );

    assign ready_s = |req_s;

    fdc_sync_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hit   (rd_hit),
        .ready_s  (ready_s),
        .wait_req (cpu_wait)
    );

    fdc_sync_latch #(.DATA_W(DATA_W), .NUM_DRV(NUM_DRV)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wdata     (io_wdata),
        .drv_sel_n (drv_sel_n),
        .head_sel  (head_sel),
        .dens_dbl  (dens_dbl)
    );

    always_comb begin
        io_rdata = '0;
        if (rd_hit) io_rdata[DATA_W-1] = ~req_s[1];
    end
endmodule

// File: rtl/fdc_sync_port_chk.sv
module fdc_sync_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_rd,
    input logic       io_wr,
    input logic [7:0] io_addr,
    input logic [7:0] io_wdata,
    input logic [7:0] io_rdata,
    input logic       cpu_wait,
    input logic       fdc_drq,
    input logic       fdc_intrq,
    input logic [3:0] drv_sel_n,
    input logic       head_sel,
    input logic       dens_dbl
);
    logic hit;
    assign hit = (io_addr == 8'h14);

    // R1
    wait_only_on_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |-> (io_rd && hit));

    // R5
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rdata != 8'h00) |-> (io_rd && hit && io_rdata == 8'h80));

    // R6
    one_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~drv_sel_n) == 1);

    // R7
    head_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit) |=> (head_sel == $past(io_wdata[2])));

    // R8
    dens_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit) |=> (dens_dbl == $past(io_wdata[3])));

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && hit) |=> $stable({drv_sel_n, head_sel, dens_dbl}));

    // R3
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_wait) && io_rd) |-> $past(fdc_drq || fdc_intrq, 3));
endmodule

bind fdc_sync_port fdc_sync_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .cpu_wait  (cpu_wait),
    .fdc_drq   (fdc_drq),
    .fdc_intrq (fdc_intrq),
    .drv_sel_n (drv_sel_n),
    .head_sel  (head_sel),
    .dens_dbl  (dens_dbl)
);

// File: tb/fdc_sync_port_tb.sv
module fdc_sync_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       cpu_wait;
    logic       fdc_drq = 1'b0, fdc_intrq = 1'b0;
    logic [3:0] drv_sel_n;
    logic       head_sel, dens_dbl;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fdc_sync_port u_dut (
        .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cpu_wait(cpu_wait), .fdc_drq(fdc_drq), .fdc_intrq(fdc_intrq),
        .drv_sel_n(drv_sel_n), .head_sel(head_sel), .dens_dbl(dens_dbl)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_check(input string tag, input logic [3:0] sel, input logic h, input logic d);
        check({tag, " sel"}, {4'h0, drv_sel_n}, {4'h0, sel});
        check({tag, " head"}, {7'h0, head_sel}, {7'h0, h});
        check({tag, " dens"}, {7'h0, dens_dbl}, {7'h0, d});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] v);
        io_addr = a; io_wdata = v; io_wr = 1'b1;
        edges(1);
        io_wr = 1'b0; io_addr = 8'h00;
        #1;
    endtask

    task automatic end_read();
        io_rd = 1'b0; io_addr = 8'h00;
        edges(1);
    endtask

    task automatic t_reset();
        edges(3);
        rst_n = 1'b1;
        edges(1);
        // R9
        cfg_check("R9 reset", 4'b1110, 1'b0, 1'b0);
        check("R9 wait after reset", {7'h0, cpu_wait}, 8'h00);
    endtask

    task automatic t_fields();
        for (int d = 0; d < 4; d++) begin
            do_write(8'h14, 8'(d) | ((d % 2 == 1) ? 8'h04 : 8'h00) | ((d >= 2) ? 8'h08 : 8'h00));
            // R6 R7 R8
            cfg_check("R6 R7 R8 field", ~(4'b0001 << d), (d % 2 == 1), (d >= 2));
        end
    endtask

    task automatic t_upper_ignored();
        do_write(8'h14, 8'hF5);
        // R8: upper nibble ignored, drive 1 head 1 single
        cfg_check("R8 upper bits", 4'b1101, 1'b1, 1'b0);
        do_write(8'h14, 8'hF0);
        cfg_check("R8 upper only", 4'b1110, 1'b0, 1'b0);
    endtask

    task automatic t_other_addr();
        do_write(8'h14, 8'h0E);
        do_write(8'h15, 8'h01);
        // R1
        cfg_check("R1 other write", 4'b1011, 1'b1, 1'b1);
        io_addr = 8'h13; io_rd = 1'b1;
        #1;
        check("R1 other read wait", {7'h0, cpu_wait}, 8'h00);
        check("R1 other read data", io_rdata, 8'h00);
        edges(2);
        check("R1 other read held", {7'h0, cpu_wait}, 8'h00);
        end_read();
    endtask

    task automatic t_stall(input bit use_intrq);
        io_addr = 8'h14; io_rd = 1'b1;
        #1;
        // R2
        check("R2 wait at strobe", {7'h0, cpu_wait}, 8'h01);
        check("R5 data no intrq", io_rdata, 8'h80);
        edges(4);
        check("R2 wait held", {7'h0, cpu_wait}, 8'h01);
        if (use_intrq) fdc_intrq = 1'b1; else fdc_drq = 1'b1;
        edges(2);
        // R3
        check("R3 wait after two edges", {7'h0, cpu_wait}, 8'h01);
        edges(1);
        check("R3 wait after three edges", {7'h0, cpu_wait}, 8'h00);
        // R5
        check("R5 read data", io_rdata, use_intrq ? 8'h00 : 8'h80);
        // R10
        fdc_drq = 1'b0; fdc_intrq = 1'b0;
        edges(5);
        check("R10 stays released", {7'h0, cpu_wait}, 8'h00);
        end_read();
        io_addr = 8'h14; io_rd = 1'b1;
        #1;
        check("R10 next read stalls", {7'h0, cpu_wait}, 8'h01);
        end_read();
        #1;
        check("R10 idle wait", {7'h0, cpu_wait}, 8'h00);
    endtask

    task automatic t_ready_first();
        fdc_drq = 1'b1;
        edges(3);
        io_addr = 8'h14; io_rd = 1'b1;
        #1;
        // R4
        check("R4 no wait at strobe", {7'h0, cpu_wait}, 8'h00);
        edges(3);
        check("R4 no wait later", {7'h0, cpu_wait}, 8'h00);
        end_read();
        fdc_drq = 1'b0;
        edges(3);
    endtask

    initial begin
        t_reset();
        t_fields();
        t_upper_ignored();
        t_other_addr();
        t_stall(1'b0);
        t_stall(1'b1);
        t_ready_first();
        edges(2);
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule